// File: doc/BRIEF.md
# Buffered SPI Master Channel

This block is the master side of a serial peripheral link with one word of buffering on each side of its shift register. A host writes a word into the transmit holding register; as soon as the shifter is free the word is moved into it, the holding register reports empty again, and the shifter produces one serial clock per bit while sending on `spi_sdo` and capturing `spi_sdi`. When the last bit has been captured the received word lands in the receive holding register and a status flag tells the host to collect it. Reception always rides on transmission, so a host that only wants to read sends filler words.

Because the next word can be parked while the current one shifts, a host that refills the transmit register before the current word ends gets an unbroken serial clock across words. Status covers transmit-empty, receive-full, overrun (a word completed while the previous one was still unread, which replaces it) and transfer-end (the shifter stopped with nothing queued). Each status bit has its own interrupt enable, and `irq` is their registered OR. Chip select is not handled here.

Register map on `bus_addr`: 0 = config (bits [3:0] word length minus one, bits [11:4] half-period minus one of the serial clock in system clocks); 1 = transmit data (write); 2 = receive data (read, right-aligned, unused upper bits zero); 3 = status (bit0 transmit-empty, bit1 receive-full, bit2 overrun, bit3 transfer-end; writing 1 clears bit2/bit3, bits 0 and 1 ignore writes); 4 = interrupt enables, same bit positions as status. Reads return data on `bus_rdata` one clock after `bus_rd`.

Top module: `spi_buf_master`

## Requirements
- R1: After reset the status register reads 0x1 (transmit-empty only), `spi_sclk` is low and `irq` is low.
- R2: A write to address 1 starts a word of (config length + 1) serial clock pulses; `spi_sclk` idles low and each high and low phase lasts (config divider + 1) system clocks.
- R3: Data leaves on `spi_sdo` most significant bit first, changes only when `spi_sclk` falls (or when a word is loaded), and keeps its last bit while the channel is idle.
- R4: `spi_sdi` is sampled on each rising `spi_sclk`, first bit received becoming the most significant of the word, which reads back right-aligned at address 2 with zero upper bits.
- R5: Status bit0 returns to 1 the cycle the buffered word moves into the shifter and reads 0 while a written word waits in the buffer.
- R6: If the transmit register is refilled before the current word ends, the next word follows with no extra low time on `spi_sclk`.
- R7: Status bit1 sets when a word completes and clears only by reading address 2.
- R8: A word completing while bit1 is set overwrites the receive register and sets bit2; bit2 clears by writing 1 to it.
- R9: Bit3 sets when a word ends with no word queued and clears by writing 1 to it.
- R10: `irq` is high exactly when some status bit and its enable at address 4 are both 1 (one clock of latency).
- R11: Length and divider are captured when a word starts; a config write during a word affects only later words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rd | input | 1 | Register read strobe |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data to the slave |
| spi_sdi | input | 1 | Serial data from the slave |

## Verification
The bench targets the word boundary: it measures every low and high phase of the serial clock inside bursts, so a design that inserts an idle phase on reload, or reloads one half-period late, shows a longer low run. It leaves two words unread to force an overrun, where a design that kept the old word or forgot the flag returns the wrong data or status, and it rewrites the length mid-word, which a design that reads the live config would turn into a wrong pulse count. One-bit and sixteen-bit words catch off-by-one errors in the bit counter and the alignment of the first transmitted bit.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;

  localparam int NFLAG  = 4;
  localparam int F_TBE  = 0;
  localparam int F_RXF  = 1;
  localparam int F_OVR  = 2;
  localparam int F_TEND = 3;
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == half_div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == half_div);

  p_cnt_bounded_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= half_div));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_valid,
  input  logic [DATA_W-1:0] buf_data,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tick,
  input  logic              sdi,
  output logic              busy,
  output logic              sclk,
  output logic              sdo,
  output logic [DIV_W-1:0]  div_q,
  output logic              load,
  output logic              done,
  output logic [DATA_W-1:0] rx_word
);
  localparam logic [LEN_W-1:0] TOP = LEN_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sr, rx_sr, aligned;
  logic [LEN_W-1:0]  cnt, len_q;
  logic              last;

  assign last    = (cnt == '0);
  assign done    = busy && tick && sclk && last;
  assign load    = buf_valid && (!busy || done);
  assign aligned = buf_data << (TOP - cfg_len);
  assign rx_word = rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sclk  <= 1'b0;
      sdo   <= 1'b0;
      tx_sr <= '0;
      rx_sr <= '0;
      cnt   <= '0;
      len_q <= '0;
      div_q <= '0;
    end else begin
      if (busy && tick) begin
        if (!sclk) begin
          sclk  <= 1'b1;
          rx_sr <= {rx_sr[DATA_W-2:0], sdi};
        end else begin
          sclk <= 1'b0;
          if (!last) begin
            tx_sr <= tx_sr << 1;
            sdo   <= tx_sr[DATA_W-2];
            cnt   <= cnt - 1'b1;
          end else if (!buf_valid) begin
            busy <= 1'b0;
          end
        end
      end
      if (load) begin
        busy  <= 1'b1;
        tx_sr <= aligned;
        sdo   <= buf_data[cfg_len];
        cnt   <= cfg_len;
        len_q <= cfg_len;
        div_q <= cfg_div;
        rx_sr <= '0;
      end
    end
  end

  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  p_cnt_in_len_r11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= len_q));
  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(load)) |-> $stable(sdo));
  p_sdo_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(sdo)) |-> $fell(sclk));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_buf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  localparam int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              load,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_word,
  output logic              buf_valid,
  output logic [DATA_W-1:0] buf_data,
  output logic [LEN_W-1:0]  cfg_len,
  output logic [DIV_W-1:0]  cfg_div,
  output logic              irq
);
  logic [DATA_W-1:0] rx_buf;
  logic              rxf, ovr, tend;
  logic [NFLAG-1:0]  ien, flags;
  logic              wr_cfg, wr_tx, wr_stat, wr_ien, rd_rx;

  assign wr_cfg  = bus_wr && (bus_addr == A_CFG);
  assign wr_tx   = bus_wr && (bus_addr == A_TX);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_ien  = bus_wr && (bus_addr == A_IEN);
  assign rd_rx   = bus_rd && (bus_addr == A_RX);

  always_comb begin
    flags         = '0;
    flags[F_TBE]  = !buf_valid;
    flags[F_RXF]  = rxf;
    flags[F_OVR]  = ovr;
    flags[F_TEND] = tend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_valid <= 1'b0;
      buf_data  <= '0;
      cfg_len   <= '0;
      cfg_div   <= '0;
      ien       <= '0;
    end else begin
      if (load) buf_valid <= 1'b0;
      if (wr_tx) begin
        buf_valid <= 1'b1;
        buf_data  <= bus_wdata;
      end
      if (wr_cfg) begin
        cfg_len <= bus_wdata[LEN_W-1:0];
        cfg_div <= bus_wdata[LEN_W +: DIV_W];
      end
      if (wr_ien) ien <= bus_wdata[NFLAG-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf <= '0;
      rxf    <= 1'b0;
      ovr    <= 1'b0;
      tend   <= 1'b0;
    end else begin
      if (rd_rx) rxf <= 1'b0;
      if (wr_stat && bus_wdata[F_OVR])  ovr  <= 1'b0;
      if (wr_stat && bus_wdata[F_TEND]) tend <= 1'b0;
      if (done) begin
        rx_buf <= rx_word;
        rxf    <= 1'b1;
        if (rxf) ovr <= 1'b1;
        if (!buf_valid) tend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(flags & ien);
      if (bus_rd) begin
        bus_rdata <= '0;
        case (bus_addr)
          A_CFG: begin
            bus_rdata[LEN_W-1:0]      <= cfg_len;
            bus_rdata[LEN_W +: DIV_W] <= cfg_div;
          end
          A_RX:   bus_rdata <= rx_buf;
          A_STAT: bus_rdata[NFLAG-1:0] <= flags;
          A_IEN:  bus_rdata[NFLAG-1:0] <= ien;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  p_tbe_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_tx) |=> !buf_valid);
  p_rxf_on_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> rxf);
  p_ovr_on_clash_r8: assert property (@(posedge clk) disable iff (rst)
    (done && rxf) |=> ovr);
  p_tend_on_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !buf_valid) |=> tend);
  p_irq_follows_r10: assert property (@(posedge clk) disable iff (rst)
    (flags & ien) == '0 |=> !irq);
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_sdo,
  input  logic              spi_sdi
);
  localparam int LEN_W = $clog2(DATA_W);

  logic              buf_valid, load, done, busy, tick;
  logic [DATA_W-1:0] buf_data, rx_word;
  logic [LEN_W-1:0]  cfg_len;
  logic [DIV_W-1:0]  cfg_div, div_q;

  spi_regfile #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .load(load), .done(done), .rx_word(rx_word),
    .buf_valid(buf_valid), .buf_data(buf_data),
    .cfg_len(cfg_len), .cfg_div(cfg_div), .irq(irq)
  );

  spi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .half_div(div_q), .tick(tick)
  );

  spi_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst),
    .buf_valid(buf_valid), .buf_data(buf_data),
    .cfg_len(cfg_len), .cfg_div(cfg_div),
    .tick(tick), .sdi(spi_sdi),
    .busy(busy), .sclk(spi_sclk), .sdo(spi_sdo), .div_q(div_q),
    .load(load), .done(done), .rx_word(rx_word)
  );
endmodule

// File: tb/spi_buf_master_tb.sv
module spi_buf_master_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_rdata;
  logic        irq, spi_sclk, spi_sdo, spi_sdi;

  int checks = 0, failures = 0;
  int sdi_idx = 0, bitpos = 0, rises = 0;
  int lowrun = 0, highrun = 0, maxlow = 0, maxhigh = 0;
  bit seen_rise = 0;
  bit mosi_q[$];

  always #2.5 clk = ~clk;

  spi_buf_master u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_sdo(spi_sdo), .spi_sdi(spi_sdi)
  );

  function automatic bit fbit(int i);
    return 1'(((i * 7) ^ (i >> 3) ^ (i >> 1)) & 1);
  endfunction

  function automatic logic [15:0] exp_rx(int base, int n);
    logic [15:0] v = '0;
    for (int j = 0; j < n; j++) v = {v[14:0], fbit(base + j)};
    return v;
  endfunction

  assign spi_sdi = fbit(sdi_idx);

  always @(negedge spi_sclk) if (!rst) sdi_idx++;
  always @(posedge spi_sclk) if (!rst) begin
    rises++;
    mosi_q.push_back(spi_sdo);
  end

  always @(negedge clk) begin
    if (spi_sclk) begin
      if (seen_rise && lowrun > 0 && lowrun > maxlow) maxlow = lowrun;
      if (lowrun > 0) seen_rise = 1;
      lowrun = 0;
      highrun++;
    end else begin
      if (highrun > maxhigh) maxhigh = highrun;
      highrun = 0;
      lowrun++;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_flag(int b);
    logic [15:0] f;
    f = '0;
    while (!f[b]) reg_rd(3'd3, f);
  endtask

  task automatic reset_mon();
    rises = 0; mosi_q.delete();
    seen_rise = 0; maxlow = 0; maxhigh = 0;
  endtask

  task automatic chk_mosi(logic [15:0] w, int n, string req);
    logic [15:0] got = '0;
    for (int j = 0; j < n; j++) begin
      if (mosi_q.size() > 0) got = {got[14:0], mosi_q.pop_front()};
      else got = {got[14:0], 1'b0};
    end
    chk(got == (w & 16'((32'h1 << n) - 1)), req, got, w & 16'((32'h1 << n) - 1));
  endtask

  task automatic single_xfer(int len, int div, logic [15:0] d);
    logic [15:0] r;
    reset_mon();
    reg_wr(3'd0, 16'((div << 4) | len));
    reg_wr(3'd1, d);
    wait_flag(3);
    chk(rises == len + 1, "R2 pulse count", rises, len + 1);
    reg_rd(3'd2, r);
    chk(r == exp_rx(bitpos, len + 1), "R4 single rx", r, exp_rx(bitpos, len + 1));
    bitpos += len + 1;
    chk_mosi(d, len + 1, "R3 single mosi");
    repeat (5) @(negedge clk);
    chk(spi_sdo == d[0] && !spi_sclk, "R3 sdo hold idle", spi_sdo, d[0]);
    reg_wr(3'd3, 16'h8);
    reg_rd(3'd3, r);
    chk(r == 16'h1, "R9 tend cleared", r, 16'h1);
  endtask

  task automatic burst(int n, int len, int div);
    logic [15:0] d[6];
    logic [15:0] r;
    int base;
    for (int k = 0; k < n; k++) d[k] = 16'($urandom);
    reset_mon();
    base = bitpos;
    reg_wr(3'd0, 16'((div << 4) | len));
    reg_wr(3'd1, d[0]);
    reg_rd(3'd3, r);
    chk(r[0] == 1'b1, "R5 tbe after load", r[0], 1);
    for (int k = 1; k < n; k++) begin
      reg_wr(3'd1, d[k]);
      if (k == 1) begin
        reg_rd(3'd3, r);
        chk(r[0] == 1'b0, "R5 tbe while queued", r[0], 0);
      end
      wait_flag(1);
      reg_rd(3'd2, r);
      chk(r == exp_rx(base + (k - 1) * (len + 1), len + 1), "R4 R7 burst rx",
          r, exp_rx(base + (k - 1) * (len + 1), len + 1));
    end
    wait_flag(1);
    reg_rd(3'd2, r);
    chk(r == exp_rx(base + (n - 1) * (len + 1), len + 1), "R4 burst last rx",
        r, exp_rx(base + (n - 1) * (len + 1), len + 1));
    wait_flag(3);
    bitpos = base + n * (len + 1);
    chk(rises == n * (len + 1), "R2 burst pulses", rises, n * (len + 1));
    chk(maxlow == div + 1, "R6 no gap low phase", maxlow, div + 1);
    chk(maxhigh == div + 1, "R2 high phase", maxhigh, div + 1);
    reg_rd(3'd3, r);
    chk(r == 16'h9, "R9 end status", r, 16'h9);
    for (int k = 0; k < n; k++) chk_mosi(d[k], len + 1, "R3 burst mosi");
    reg_wr(3'd3, 16'h8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!spi_sclk, "R1 sclk low", spi_sclk, 0);
    chk(!irq, "R1 irq low", irq, 0);
    reg_rd(3'd3, r);
    chk(r == 16'h1, "R1 status", r, 16'h1);

    // one-bit and full-width words
    single_xfer(0, 0, 16'h0001);
    single_xfer(0, 1, 16'h0000);
    single_xfer(15, 2, 16'hA5C3);

    // random back-to-back bursts
    for (int b = 0; b < 6; b++)
      burst(3 + int'($urandom % 4), 5 + int'($urandom % 11), 1 + int'($urandom % 3));

    // R8 overrun
    reset_mon();
    reg_wr(3'd0, 16'h0017);
    reg_wr(3'd1, 16'h0055);
    reg_wr(3'd1, 16'h00C6);
    wait_flag(3);
    reg_rd(3'd3, r);
    chk(r == 16'hF, "R8 overrun status", r, 16'hF);
    reg_wr(3'd3, 16'h3);
    reg_rd(3'd3, r);
    chk(r == 16'hF, "R7 rxf ignores write", r, 16'hF);
    reg_wr(3'd3, 16'hC);
    reg_rd(3'd3, r);
    chk(r == 16'h3, "R8 overrun cleared", r, 16'h3);
    reg_rd(3'd2, r);
    chk(r == exp_rx(bitpos + 8, 8), "R8 newest word kept", r, exp_rx(bitpos + 8, 8));
    bitpos += 16;
    reg_rd(3'd3, r);
    chk(r == 16'h1, "R7 rxf cleared by read", r, 16'h1);

    // R11 length captured at word start
    reset_mon();
    reg_wr(3'd0, 16'h0017);
    reg_wr(3'd1, 16'h00B4);
    reg_wr(3'd0, 16'h0013);
    wait_flag(3);
    chk(rises == 8, "R11 old length kept", rises, 8);
    reg_rd(3'd2, r);
    chk(r == exp_rx(bitpos, 8), "R11 rx old length", r, exp_rx(bitpos, 8));
    bitpos += 8;
    reg_wr(3'd3, 16'h8);
    reg_wr(3'd1, 16'h0009);
    wait_flag(3);
    chk(rises == 12, "R11 new length used", rises, 12);
    reg_rd(3'd2, r);
    chk(r == exp_rx(bitpos, 4), "R11 rx new length", r, exp_rx(bitpos, 4));
    bitpos += 4;

    // R10 interrupt
    reg_wr(3'd4, 16'h2);
    repeat (2) @(negedge clk);
    chk(!irq, "R10 masked flags", irq, 0);
    reg_wr(3'd1, 16'h0003);
    wait_flag(1);
    repeat (2) @(negedge clk);
    chk(irq, "R10 rxf irq", irq, 1);
    reg_rd(3'd2, r);
    bitpos += 4;
    repeat (2) @(negedge clk);
    chk(!irq, "R10 irq drops", irq, 0);
    reg_wr(3'd4, 16'h8);
    repeat (2) @(negedge clk);
    chk(irq, "R10 tend irq", irq, 1);
    reg_wr(3'd3, 16'h8);
    repeat (2) @(negedge clk);
    chk(!irq, "R10 tend cleared irq", irq, 0);
    reg_wr(3'd4, 16'h1);
    repeat (2) @(negedge clk);
    chk(irq, "R10 tbe irq", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule